// File: doc/BRIEF.md
# Down-Counting Compare Timer with Control Word

This block is a physical countdown timer that raises a level-sensitive interrupt once its count runs out. Software loads a 32-bit count through a dedicated load port; from then on the count drops by one on every cycle in which the free-running `tick_i` input is high. The count is treated as a signed number, and the timer is considered expired whenever it is zero or negative. The count keeps running after expiry and wraps modulo 2^32.

A 64-bit control word is read and written through a simple register port. It holds an enable flag, an interrupt mask flag and a read-only status flag. The enable flag gates only the interrupt path, so the count keeps moving while the timer is disabled. The status flag reports the raw expiry condition and does not depend on the mask. The interrupt output is high only when the timer is enabled, expired and unmasked.

Top module: `dtmr_top`

## Requirements
- R1: After reset the control word reads as all zeros, the interrupt output is low and the count reads 0.
- R2: A control write stores bit 0 as the enable flag and bit 1 as the mask flag, and both read back at the same positions from the cycle after the write.
- R3: Bits 63 down to 3 of the control word always read as zero, and a write to bit 2 or to any of those bits has no effect.
- R4: While enabled, bit 2 of the control word reads 1 exactly when the count taken as signed 32-bit is less than or equal to zero, whatever the mask flag holds.
- R5: While the enable flag is 0, bit 2 of the control word reads 0.
- R6: The interrupt output is high exactly when the enable flag is 1, the expiry condition holds and the mask flag is 0. Clearing enable drops it.
- R7: The count decrements by one in each cycle that `tick_i` is high, whether or not the timer is enabled, and wraps from 0 to 0xFFFFFFFF and from 0x80000000 to 0x7FFFFFFF.
- R8: A load on the count port sets the count to the written value from the next cycle on, and a tick in the load cycle is ignored.
- R9: A control write with bit 1 set drops the interrupt output in the first cycle after the write is sampled, the same cycle in which the new control value becomes visible.
- R10: At the signed boundaries, a count of 0 or 0x80000000 counts as expired and a count of 1 or 0x7FFFFFFF does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable from the free-running time base |
| cnt_wr_i | input | 1 | Load strobe for the count |
| cnt_wdata_i | input | 32 | Value to load into the count |
| cnt_o | output | 32 | Current count |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 64 | Control word write data |
| ctl_rdata_o | output | 64 | Control word read data |
| irq_o | output | 1 | Level-sensitive timer interrupt |

## Verification
The hardest cases to reach from the ports are the two signed wrap points, where one tick moves the count between expired and not expired. Counting down from a small load value would never reach them in a practical run. The stimulus therefore loads values right next to zero and next to the sign boundary, then applies a tick or two. It also collides a load with a tick, and it sets the mask bit while the interrupt is high, so it can observe the exact cycle in which the interrupt drops.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
   // field positions inside the control word, decoded by software
   localparam int unsigned EN_POS   = 0;
   localparam int unsigned MASK_POS = 1;
   localparam int unsigned STAT_POS = 2;
   localparam int unsigned USED_W   = 3;

   typedef struct packed {
      logic mask;
      logic en;
   } dtmr_ctl_t;
endpackage

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expired_o
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   initial begin
      assert (CNT_W >= 2) else $error("dtmr_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (tick_i) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   // signed value <= 0 : sign bit set or all zero
   assign expired_o = cnt_q[CNT_W-1] | (cnt_q == '0);
   assign cnt_o     = cnt_q;

   // R8
   load_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> cnt_q == $past(load_val_i));

   // R7
   tick_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && tick_i) |=> cnt_q == $past(cnt_q) - ONE);

   // R7
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dtmr_ctl_reg.sv
module dtmr_ctl_reg
   import dtmr_pkg::*;
#(
   parameter int unsigned CTRL_W = 64
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [CTRL_W-1:0] wdata_i,
   input  logic              expired_i,
   output logic [CTRL_W-1:0] rdata_o,
   output dtmr_ctl_t         ctl_o
);
   initial begin
      assert (CTRL_W >= USED_W) else $error("dtmr_ctl_reg: CTRL_W too narrow");
   end

   dtmr_ctl_t ctl_q;
   logic      status;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctl_q <= '0;
      end else if (wr_i) begin
         ctl_q.en   <= wdata_i[EN_POS];
         ctl_q.mask <= wdata_i[MASK_POS];
      end
   end

   // status has no meaning while disabled; reads 0 then
   assign status = ctl_q.en & expired_i;

   assign rdata_o[EN_POS]   = ctl_q.en;
   assign rdata_o[MASK_POS] = ctl_q.mask;
   assign rdata_o[STAT_POS] = status;

   generate
      if (CTRL_W > USED_W) begin : g_rsvd
         for (genvar b = USED_W; b < CTRL_W; b++) begin : g_bit
            assign rdata_o[b] = 1'b0;
         end
         logic unused_wdata;
         assign unused_wdata = ^{wdata_i[CTRL_W-1:USED_W], wdata_i[STAT_POS]};
      end else begin : g_norsvd
         logic unused_wdata;
         assign unused_wdata = wdata_i[STAT_POS];
      end
   endgenerate

   assign ctl_o = ctl_q;

   // R2
   ctl_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> (rdata_o[EN_POS] == $past(wdata_i[EN_POS])) &&
               (rdata_o[MASK_POS] == $past(wdata_i[MASK_POS])));

   // R2
   ctl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> $stable(ctl_q));

   // R5
   stat_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rdata_o[EN_POS] |-> !rdata_o[STAT_POS]);
endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq
   import dtmr_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  dtmr_ctl_t ctl_i,
   input  logic      expired_i,
   output logic      irq_o
);
   always_comb begin
      irq_o = 1'b0;
      if (ctl_i.en && !ctl_i.mask) begin
         irq_o = expired_i;
      end
   end

   // R6
   irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> ctl_i.en && !ctl_i.mask && expired_i);
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
   import dtmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned CTRL_W = 64
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              cnt_wr_i,
   input  logic [CNT_W-1:0]  cnt_wdata_i,
   output logic [CNT_W-1:0]  cnt_o,
   input  logic              ctl_wr_i,
   input  logic [CTRL_W-1:0] ctl_wdata_i,
   output logic [CTRL_W-1:0] ctl_rdata_o,
   output logic              irq_o
);
   logic      expired;
   dtmr_ctl_t ctl;

   dtmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .load_i     (cnt_wr_i),
      .load_val_i (cnt_wdata_i),
      .cnt_o      (cnt_o),
      .expired_o  (expired)
   );

   dtmr_ctl_reg #(.CTRL_W(CTRL_W)) u_ctl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (ctl_wr_i),
      .wdata_i   (ctl_wdata_i),
      .expired_i (expired),
      .rdata_o   (ctl_rdata_o),
      .ctl_o     (ctl)
   );

   dtmr_irq u_irq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctl_i     (ctl),
      .expired_i (expired),
      .irq_o     (irq_o)
   );

   // R9
   mask_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_wr_i && ctl_wdata_i[MASK_POS]) |=> !irq_o);

   // R4
   stat_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctl_rdata_o[EN_POS] |-> ctl_rdata_o[STAT_POS] == ($signed(cnt_o) <= 0));
endmodule

// File: tb/dtmr_top_tb.sv
module dtmr_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        cnt_wr = 1'b0;
   logic [31:0] cnt_wdata = '0;
   logic [31:0] cnt;
   logic        ctl_wr = 1'b0;
   logic [63:0] ctl_wdata = '0;
   logic [63:0] ctl_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk; // 250 MHz

   dtmr_top u_dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
      .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata), .cnt_o(cnt),
      .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
      .irq_o(irq)
   );

   // ctl write, count load, ticks, expected ctl[2:0], expected irq
   typedef struct packed {
      logic [63:0] ctl;
      logic [31:0] val;
      logic [7:0]  n;
      logic [2:0]  st;
      logic        irq;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VT [NV] = '{
      '{64'h1, 32'd5,        8'd3, 3'b001, 1'b0},  // R4 not yet expired
      '{64'h1, 32'd5,        8'd5, 3'b101, 1'b1},  // R4 R6 R10 zero
      '{64'h3, 32'd2,        8'd4, 3'b111, 1'b0},  // R4 masked, status raw
      '{64'h0, 32'd0,        8'd0, 3'b000, 1'b0},  // R5 disabled
      '{64'h5, 32'd10,       8'd1, 3'b001, 1'b0},  // R3 bit2 write ignored
      '{64'h1, 32'h80000000, 8'd0, 3'b101, 1'b1},  // R10 most negative
      '{64'h1, 32'h7FFFFFFF, 8'd0, 3'b001, 1'b0},  // R10 most positive
      '{64'h1, 32'd0,        8'd1, 3'b101, 1'b1},  // R7 wrap to -1
      '{64'h2, 32'd0,        8'd0, 3'b010, 1'b0},  // R5 masked disabled
      '{64'hFFFF_FFFF_FFFF_FFF9, 32'd1, 8'd0, 3'b001, 1'b0}, // R3 reserved
      '{64'h1, 32'h80000000, 8'd1, 3'b001, 1'b0}   // R7 R10 sign wrap
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         step();
      end
      tick = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rdata", ctl_rdata, 64'h0);
      chk("R1 irq", {63'b0, irq}, 64'h0);
      chk("R1 count", {32'b0, cnt}, 64'h0);
      rst_n = 1'b1;
      step();
      chk("R1 after release", ctl_rdata, 64'h0);

      // table walk
      for (int k = 0; k < NV; k++) begin
         ctl_wr = 1'b1; ctl_wdata = VT[k].ctl;
         cnt_wr = 1'b1; cnt_wdata = VT[k].val;
         step();
         ctl_wr = 1'b0; cnt_wr = 1'b0;
         chk("R2 R8 load visible", {32'b0, cnt}, {32'b0, VT[k].val});
         do_ticks(int'(VT[k].n));
         chk("R4 R5 R3 ctl word", ctl_rdata, {61'b0, VT[k].st});
         chk("R6 irq", {63'b0, irq}, {63'b0, VT[k].irq});
         chk("R7 count", {32'b0, cnt}, {32'b0, VT[k].val - 32'(VT[k].n)});
      end

      // R7 counting continues while disabled
      ctl_wr = 1'b1; ctl_wdata = 64'h0; cnt_wr = 1'b1; cnt_wdata = 32'd100;
      step();
      ctl_wr = 1'b0; cnt_wr = 1'b0;
      do_ticks(10);
      chk("R7 disabled count", {32'b0, cnt}, 64'd90);
      chk("R6 disabled irq", {63'b0, irq}, 64'h0);

      // R8 tick during load ignored
      tick = 1'b1; cnt_wr = 1'b1; cnt_wdata = 32'd50;
      step();
      cnt_wr = 1'b0; tick = 1'b0;
      chk("R8 load beats tick", {32'b0, cnt}, 64'd50);

      // R9 mask drops irq in the commit cycle
      cnt_wr = 1'b1; cnt_wdata = 32'd0; ctl_wr = 1'b1; ctl_wdata = 64'h1;
      step();
      cnt_wr = 1'b0; ctl_wr = 1'b0;
      chk("R6 irq high", {63'b0, irq}, 64'h1);
      ctl_wr = 1'b1; ctl_wdata = 64'h3;
      #1;
      chk("R9 irq before commit", {63'b0, irq}, 64'h1);
      step();
      ctl_wr = 1'b0;
      chk("R9 irq after commit", {63'b0, irq}, 64'h0);
      chk("R4 status ignores mask", ctl_rdata, 64'h7);

      // R6 clearing enable drops irq while count still runs
      ctl_wr = 1'b1; ctl_wdata = 64'h1;
      step();
      ctl_wr = 1'b0;
      chk("R6 irq back", {63'b0, irq}, 64'h1);
      ctl_wr = 1'b1; ctl_wdata = 64'h0;
      step();
      ctl_wr = 1'b0;
      chk("R6 disable drops irq", {63'b0, irq}, 64'h0);
      chk("R5 status zero when off", ctl_rdata, 64'h0);
      do_ticks(2);
      chk("R7 count after disable", {32'b0, cnt}, {32'b0, 32'hFFFFFFFE});

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule